// File: doc/BRIEF.md
# Button-Sequence PIN Lock Controller

This block is a combination lock driven by four push buttons. Every press of a single button adds one two-bit symbol to the entry being built, and the symbol is the index of the pressed button. An entry is complete after `CODE_LEN` symbols. While the lock is open, the user must key the same sequence twice in a row to arm it. The matched sequence then becomes the stored code. While the lock is armed, keying the stored code opens it again. A failed comparison raises an error flag and does not change the lock state.

The block expects clean, synchronous, active-high button levels, so debouncing must happen upstream. A partial entry is dropped if no press arrives within `TIMEOUT_CYCLES` clock cycles. A two-bit display code tells a downstream glyph driver whether to show the open, locked, error or awaiting-confirmation message.

Top module: `pinlock_ctrl`

## Requirements
- R1: A press is the rising edge of exactly one button level. It appends the symbol equal to that button's index (`btn_i[k]` gives symbol k). A button held high for many cycles gives only one symbol.
- R2: A cycle in which two or more buttons rise together adds no symbol.
- R3: While open, completing the first entry of `CODE_LEN` symbols moves the block to the awaiting-confirmation phase. The lock stays open.
- R4: While awaiting confirmation, a second entry equal to the first, symbol for symbol, locks the block and becomes the stored code.
- R5: While awaiting confirmation, a second entry that differs from the first leaves the block open, drops the first entry and raises the error flag.
- R6: While locked, an entry equal to the stored code opens the block.
- R7: While locked, an entry that differs from the stored code keeps the block locked and raises the error flag.
- R8: The error flag stays high until the next press. That press clears the flag and counts as the first symbol of a new entry.
- R9: During a partial entry, a press that arrives more than `TIMEOUT_CYCLES` cycles after the previous accepted press starts a fresh entry. A press that arrives at or within that distance continues the current entry. The lock state does not change on a timeout.
- R10: A timeout while awaiting confirmation drops both entries and returns to the open first-entry phase.
- R11: After reset the block is open, the error flag is low, no entry is in progress and `disp_o` reads 0.
- R12: `disp_o` encodes 0 as open, 1 as locked, 2 as error and 3 as open and awaiting confirmation. The error code has priority over the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 4 | Button levels, high while pressed |
| locked_o | output | 1 | High while the lock is armed |
| error_o | output | 1 | High after a failed comparison, until the next press |
| disp_o | output | 2 | Message code for the display driver (see R12) |

## Verification
The bench tests the timeout boundary in both directions. A press exactly at the limit must extend the entry, and one cycle later it must start over. A design off by one in the idle counter either opens on a short fresh entry or refuses a valid one. The bench lets a timeout discard the first half of an unlock attempt and then keys symbols that would match only if the stale half were kept. It also times out the confirming entry, so that a design which keeps the first entry locks after a single re-entry. Finally, the bench sends simultaneous edges and a long hold, and counts symbols to show that neither adds more than the rules allow.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;

   localparam int unsigned SYM_W    = 2;
   localparam int unsigned NUM_KEYS = 4;

   typedef enum logic [1:0] {
      PH_OPEN    = 2'd0,
      PH_CONFIRM = 2'd1,
      PH_LOCKED  = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      DISP_OPEN    = 2'd0,
      DISP_LOCKED  = 2'd1,
      DISP_ERROR   = 2'd2,
      DISP_CONFIRM = 2'd3
   } disp_e;

endpackage

// File: rtl/pinlock_press_det.sv
module pinlock_press_det #(
   parameter int unsigned NUM_KEYS = 4,
   parameter int unsigned SYM_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] keys_i,
   output logic                valid_o,
   output logic [SYM_W-1:0]    sym_o
);

   localparam int unsigned HIT_W = $clog2(NUM_KEYS + 1);

   if (NUM_KEYS > (1 << SYM_W)) begin : g_bad_width
      $error("pinlock_press_det: SYM_W too narrow for NUM_KEYS");
   end
   if (NUM_KEYS < 1) begin : g_bad_keys
      $error("pinlock_press_det: NUM_KEYS must be at least 1");
   end

   logic [NUM_KEYS-1:0] prev_q;
   logic [NUM_KEYS-1:0] rise;
   logic [HIT_W-1:0]    hits;

   // keys held through reset are not counted as presses
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= keys_i;
   end

   assign rise = keys_i & ~prev_q;

   always_comb begin
      sym_o = '0;
      hits  = '0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (rise[i]) begin
            sym_o = SYM_W'(i);
            hits  = hits + 1'b1;
         end
      end
   end

   assign valid_o = (hits == HIT_W'(1));

   // a single edge never yields the same symbol on two consecutive cycles
   assert_one_symbol_per_edge_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !(valid_o && (sym_o == $past(sym_o))));

endmodule

// File: rtl/pinlock_idle_timer.sv
module pinlock_idle_timer #(
   parameter int unsigned TIMEOUT_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic kick_i,
   output logic expire_o
);

   if (TIMEOUT_CYCLES == 0) begin : g_no_timeout
      assign expire_o = 1'b0;
   end else begin : g_timeout
      localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !active_i || kick_i || cnt_q == LAST) cnt_q <= '0;
         else                                                cnt_q <= cnt_q + 1'b1;
      end

      assign expire_o = active_i && !kick_i && (cnt_q == LAST);

      assert_cnt_in_window_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
      assert_expire_restarts_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         expire_o |=> (cnt_q == '0));
   end

endmodule

// File: rtl/pinlock_seq_match.sv
module pinlock_seq_match #(
   parameter int unsigned CODE_LEN = 4,
   parameter int unsigned SYM_W    = 2
) (
   input  logic [CODE_LEN*SYM_W-1:0] a_i,
   input  logic [CODE_LEN*SYM_W-1:0] b_i,
   output logic                      eq_o
);

   logic [CODE_LEN-1:0] slot_eq;

   for (genvar s = 0; s < CODE_LEN; s++) begin : g_slot
      assign slot_eq[s] = (a_i[s*SYM_W +: SYM_W] == b_i[s*SYM_W +: SYM_W]);
   end

   assign eq_o = &slot_eq;

endmodule

// File: rtl/pinlock_ctrl.sv
module pinlock_ctrl #(
   parameter int unsigned CODE_LEN       = 4,
   parameter int unsigned TIMEOUT_CYCLES = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] btn_i,
   output logic       locked_o,
   output logic       error_o,
   output logic [1:0] disp_o
);
   import pinlock_pkg::*;

   localparam int unsigned CODE_W = CODE_LEN * SYM_W;
   localparam int unsigned IDX_W  = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_LEN - 1);

   if (CODE_LEN < 1) begin : g_bad_len
      $error("pinlock_ctrl: CODE_LEN must be at least 1");
   end

   logic             press_v;
   logic [SYM_W-1:0] press_sym;
   logic             expire;
   logic             partial;
   logic             ref_eq;

   phase_e           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [CODE_W-1:0] entry_q, first_q, stored_q;
   logic [CODE_W-1:0] entry_next, ref_code;
   logic             error_q;
   disp_e            disp;

   pinlock_press_det #(.NUM_KEYS(NUM_KEYS), .SYM_W(SYM_W)) press_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .keys_i  (btn_i),
      .valid_o (press_v),
      .sym_o   (press_sym)
   );

   assign partial = (idx_q != '0) || (phase_q == PH_CONFIRM);

   pinlock_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (partial),
      .kick_i   (press_v),
      .expire_o (expire)
   );

   always_comb begin
      entry_next = entry_q;
      entry_next[idx_q*SYM_W +: SYM_W] = press_sym;
   end

   assign ref_code = (phase_q == PH_CONFIRM) ? first_q : stored_q;

   pinlock_seq_match #(.CODE_LEN(CODE_LEN), .SYM_W(SYM_W)) match_i (
      .a_i  (entry_next),
      .b_i  (ref_code),
      .eq_o (ref_eq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_OPEN;
         idx_q    <= '0;
         entry_q  <= '0;
         first_q  <= '0;
         stored_q <= '0;
         error_q  <= 1'b0;
      end else if (press_v) begin
         error_q <= 1'b0;
         entry_q <= entry_next;
         if (idx_q == IDX_LAST) begin
            idx_q <= '0;
            unique case (phase_q)
               PH_OPEN: begin
                  first_q <= entry_next;
                  phase_q <= PH_CONFIRM;
               end
               PH_CONFIRM: begin
                  if (ref_eq) begin
                     stored_q <= entry_next;
                     phase_q  <= PH_LOCKED;
                  end else begin
                     error_q <= 1'b1;
                     phase_q <= PH_OPEN;
                  end
               end
               PH_LOCKED: begin
                  if (ref_eq) phase_q <= PH_OPEN;
                  else        error_q <= 1'b1;
               end
               default: phase_q <= PH_OPEN;
            endcase
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end else if (expire) begin
         idx_q <= '0;
         if (phase_q == PH_CONFIRM) phase_q <= PH_OPEN;
      end
   end

   always_comb begin
      if (error_q)                    disp = DISP_ERROR;
      else if (phase_q == PH_LOCKED)  disp = DISP_LOCKED;
      else if (phase_q == PH_CONFIRM) disp = DISP_CONFIRM;
      else                            disp = DISP_OPEN;
   end

   assign locked_o = (phase_q == PH_LOCKED);
   assign error_o  = error_q;
   assign disp_o   = disp;

   assert_lock_after_confirm_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(phase_q == PH_CONFIRM));
   assert_unlock_needs_press_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> $past(press_v));
   assert_error_held_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (error_q && !press_v) |=> error_q);
   assert_lock_state_kept_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !press_v |=> $stable(locked_o));
   assert_timeout_drops_entry_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (idx_q == '0) && (phase_q != PH_CONFIRM));

endmodule

// File: tb/pinlock_ctrl_tb.sv
module pinlock_ctrl_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned LEN = 4;
   localparam int unsigned TMO = 20;

   localparam logic [1:0] OP_PRESS = 2'd0;
   localparam logic [1:0] OP_WAIT  = 2'd1;
   localparam logic [1:0] D_O = 2'd0;
   localparam logic [1:0] D_L = 2'd1;
   localparam logic [1:0] D_E = 2'd2;
   localparam logic [1:0] D_C = 2'd3;

   // vector: {op[12:11], arg[10:6], expected disp[5:4], requirement[3:0]}
   function automatic logic [12:0] v(logic [1:0] op, int arg, logic [1:0] ex, int rq);
      return {op, 5'(arg), ex, 4'(rq)};
   endfunction

   localparam int NV = 56;
   localparam logic [12:0] VEC [NV] = '{
      // first entry 0123 (R1, R3)
      v(OP_PRESS,0,D_O,1), v(OP_PRESS,1,D_O,1), v(OP_PRESS,2,D_O,1), v(OP_PRESS,3,D_C,3),
      // confirm 0123 locks (R4)
      v(OP_PRESS,0,D_C,3), v(OP_PRESS,1,D_C,3), v(OP_PRESS,2,D_C,3), v(OP_PRESS,3,D_L,4),
      // wrong unlock 3210 (R7)
      v(OP_PRESS,3,D_L,7), v(OP_PRESS,2,D_L,7), v(OP_PRESS,1,D_L,7), v(OP_PRESS,0,D_E,7),
      // error cleared by press, correct unlock (R8, R6)
      v(OP_PRESS,0,D_L,8), v(OP_PRESS,1,D_L,6), v(OP_PRESS,2,D_L,6), v(OP_PRESS,3,D_O,6),
      // confirm mismatch (R5), then relock with 2200 (R8, R4)
      v(OP_PRESS,1,D_O,3), v(OP_PRESS,1,D_O,3), v(OP_PRESS,2,D_O,3), v(OP_PRESS,2,D_C,3),
      v(OP_PRESS,1,D_C,5), v(OP_PRESS,1,D_C,5), v(OP_PRESS,2,D_C,5), v(OP_PRESS,3,D_E,5),
      v(OP_PRESS,2,D_O,8), v(OP_PRESS,2,D_O,3), v(OP_PRESS,0,D_O,3), v(OP_PRESS,0,D_C,3),
      v(OP_PRESS,2,D_C,4), v(OP_PRESS,2,D_C,4), v(OP_PRESS,0,D_C,4), v(OP_PRESS,0,D_L,4),
      // timeout drops stale half of unlock (R9)
      v(OP_PRESS,2,D_L,9), v(OP_PRESS,2,D_L,9), v(OP_WAIT,25,D_L,9),
      v(OP_PRESS,0,D_L,9), v(OP_PRESS,0,D_L,9), v(OP_PRESS,2,D_L,9), v(OP_PRESS,2,D_E,9),
      // unlock with 2200 (R8, R6)
      v(OP_PRESS,2,D_L,8), v(OP_PRESS,2,D_L,6), v(OP_PRESS,0,D_L,6), v(OP_PRESS,0,D_O,6),
      // timeout while confirming (R10)
      v(OP_PRESS,3,D_O,3), v(OP_PRESS,3,D_O,3), v(OP_PRESS,3,D_O,3), v(OP_PRESS,3,D_C,3),
      v(OP_WAIT,25,D_O,10),
      v(OP_PRESS,3,D_O,10), v(OP_PRESS,3,D_O,10), v(OP_PRESS,3,D_O,10), v(OP_PRESS,3,D_C,10),
      v(OP_PRESS,3,D_C,4), v(OP_PRESS,3,D_C,4), v(OP_PRESS,3,D_C,4), v(OP_PRESS,3,D_L,4)
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] btn_i;
   logic       locked_o;
   logic       error_o;
   logic [1:0] disp_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pinlock_ctrl #(.CODE_LEN(LEN), .TIMEOUT_CYCLES(TMO)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .btn_i    (btn_i),
      .locked_o (locked_o),
      .error_o  (error_o),
      .disp_o   (disp_o)
   );

   function automatic string rname(int r);
      case (r)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   task automatic check(string rq, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic press_mask(logic [3:0] m);
      @(negedge clk) btn_i = m;
      @(negedge clk) btn_i = 4'b0000;
   endtask

   task automatic press_key(int k);
      press_mask(4'b0001 << k);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      btn_i = 4'b0000;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R11 reset state, R12 open code
      check("R11", "locked after reset", locked_o, 0);
      check("R11", "error after reset", error_o, 0);
      check("R12", "disp after reset", disp_o, 0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         int         arg, rq;
         logic [1:0] ex;
         op  = VEC[i][12:11];
         arg = int'(VEC[i][10:6]);
         ex  = VEC[i][5:4];
         rq  = int'(VEC[i][3:0]);
         if (op == OP_PRESS) press_key(arg);
         else                idle(arg);
         check(rname(rq), $sformatf("disp at step %0d", i), disp_o, ex);
         if (ex == D_E) check(rname(rq), $sformatf("error at step %0d", i), error_o, 1);
         else           check("R12", $sformatf("error at step %0d", i), error_o, 0);
         if (ex == D_L) check(rname(rq), $sformatf("locked at step %0d", i), locked_o, 1);
         if (ex == D_O || ex == D_C)
            check(rname(rq), $sformatf("locked at step %0d", i), locked_o, 0);
      end

      // R9 boundary: gap of exactly TMO cycles continues the entry (stored 3333)
      press_key(3);
      idle(TMO - 2);
      check("R9", "disp before edge press", disp_o, D_L);
      press_key(3); press_key(3); press_key(3);
      check("R9", "unlock across limit gap", locked_o, 0);

      // relock with 0000
      for (int i = 0; i < 2 * LEN; i++) press_key(0);
      check("R4", "relock 0000", locked_o, 1);

      // R9 boundary: gap of TMO+1 cycles starts a fresh entry
      press_key(0);
      idle(TMO - 1);
      press_key(0); press_key(0); press_key(0);
      check("R9", "stale symbol dropped", disp_o, D_L);
      press_key(0);
      check("R9", "fresh entry completes", disp_o, D_O);

      // R2: simultaneous edges add nothing
      press_mask(4'b0011);
      check("R2", "disp after double edge", disp_o, D_O);
      press_key(1); press_key(1); press_key(1);
      check("R2", "three symbols only", disp_o, D_O);
      press_key(1);
      check("R2", "fourth symbol completes", disp_o, D_C);

      // R1: a long hold counts once
      @(negedge clk) btn_i = 4'b0010;
      idle(5);
      btn_i = 4'b0000;
      press_key(1); press_key(1);
      check("R1", "hold gives one symbol", disp_o, D_C);
      press_key(1);
      check("R1", "confirm after hold locks", locked_o, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule